// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This unit keeps, for each channel of a 16-channel DMA engine, an interrupt enable register and an interrupt status register, and it drives the interrupt lines. Channels report events as one-cycle pulses on a six-bit event vector. Each pulse is latched into status only if the channel enables that event. The exception is the event-drop indication, which is always latched. A seventh status bit follows the level on the channel's synchronised-active input.

Software reads status through a read port. The returned word appears combinationally in the cycle of the read, and that read clears the returned event bits at the next clock edge. The sync bit is never cleared by a read. Two line mappings are selectable.

- **Legacy mapping.** Channels 0..2 are paired with channels 6..8. A pair shares one interrupt line and one status read, and only lines 0..5 are in use.
- **Extended mapping.** Each channel drives its own line and is read alone.

Top module: `dma_irq_unit`

## Requirements
- R1: Status bit n (n = 0..5) records event input bit n: 0 timeout, 1 event drop, 2 half frame, 3 end of frame, 4 last frame, 5 end of block. Bit 6 is sync-active.
- R2: An event pulse on bit n sets status bit n at the next clock edge only if enable bit n of that channel is 1. Bit 1 (event drop) is set regardless of the enable.
- R3: After reset every enable register holds 6'b000011. A write with wr_sel_i = 0 loads wr_data_i into the enable register of channel wr_ch_i.
- R4: With rd_en_i = 1, rd_data_o carries the status of channel rd_ch_i in bits 6:0 during that same cycle. Bits 5:0 of that channel are cleared at the following edge.
- R5: Paired read. In legacy mapping (ext_map_i = 0), a read of channel c in 0..2 or 6..8 whose compat_dis_i[c] = 0 also ORs the partner's status bits 5:0 into rd_data_o bits 11:6, and clears those partner bits. The partner is c+6 or c-6. With compat_dis_i[c] = 1 the partner is neither returned nor cleared.
- R6: In legacy mapping, line i (i = 0..5) is high while channel i's status is nonzero or, for i = 0..2, while channel i+6's status is nonzero. Lines 6..15 stay low.
- R7: In extended mapping (ext_map_i = 1), line c is high exactly while channel c's status is nonzero, and a read touches only the selected channel.
- R8: Status bit 6 equals sync_act_i of that channel as sampled at the previous edge, and a read does not clear it.
- R9: A write with wr_sel_i = 1 (status register) changes nothing.
- R10: If a read clears a channel in the same cycle as an event on that channel, the newly latched event bit is set after the edge.
- R11: Reset clears all status bits, so all lines are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_map_i | input | 1 | 1 selects extended mapping, 0 selects legacy mapping |
| compat_dis_i | input | 16 | Per-channel compatibility-disable bit; when 1, the channel is read without its partner |
| evt_i | input | 16x6 | Per-channel event pulses, bit layout as in R1 |
| sync_act_i | input | 16 | Per-channel synchronised-active level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the enable register, 1 selects the status register (ignored) |
| wr_ch_i | input | 4 | Channel addressed by the write |
| wr_data_i | input | 6 | Enable value to load |
| rd_en_i | input | 1 | Status read strobe |
| rd_ch_i | input | 4 | Channel addressed by the read |
| rd_data_o | output | 16 | Read data, valid in the cycle of rd_en_i; zero otherwise |
| irq_o | output | 16 | Interrupt lines |

## Verification
A channel event and a clearing status read can land on the same clock edge. In that case the event must survive the read. The bench provokes this collision on one channel by latching a timeout event and then, in a single cycle, issuing a read of that channel together with a new drop event. It judges the result in three ways:
- the read word must still show only the old timeout bit;
- the channel's line must stay high after the edge;
- a second read must return only the drop bit.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int EVT_W    = 6;
  localparam int ST_W     = 7;
  localparam int SYNC_BIT = 6;
  localparam int DROP_BIT = 1;
  localparam int RD_W     = 16;

  function automatic bit has_partner(int ch, int pairs, int ofs);
    return (ch < pairs) || ((ch >= ofs) && (ch < ofs + pairs));
  endfunction

  function automatic int partner_of(int ch, int pairs, int ofs);
    if (ch < pairs) return ch + ofs;
    if ((ch >= ofs) && (ch < ofs + pairs)) return ch - ofs;
    return ch;
  endfunction
endpackage

// File: rtl/dma_irq_ch_stat.sv
module dma_irq_ch_stat
  import dma_irq_pkg::*;
#(
  parameter logic [EVT_W-1:0] IEN_RST = 6'h03
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             sync_act_i,
  input  logic             ien_we_i,
  input  logic [EVT_W-1:0] ien_d_i,
  input  logic             clr_i,
  output logic [ST_W-1:0]  st_o
);
  localparam logic [EVT_W-1:0] DROP_MSK = EVT_W'(1) << DROP_BIT;

  logic [EVT_W-1:0] ien_q;
  logic [EVT_W-1:0] ev_q;
  logic             sync_q;
  logic [EVT_W-1:0] ev_kept;
  logic [EVT_W-1:0] ev_new;

  assign ev_kept = clr_i ? '0 : ev_q;
  assign ev_new  = evt_i & (ien_q | DROP_MSK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= IEN_RST;
      ev_q   <= '0;
      sync_q <= 1'b0;
    end else begin
      if (ien_we_i) ien_q <= ien_d_i;
      // new events win over a same-cycle clear
      ev_q   <= ev_kept | ev_new;
      sync_q <= sync_act_i;
    end
  end

  assign st_o = {sync_q, ev_q};
endmodule

// File: rtl/dma_irq_rd_path.sv
module dma_irq_rd_path
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int LEG_PAIRS = 3,
  parameter int PAIR_OFS  = 6,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic                       rd_en_i,
  input  logic [CH_W-1:0]            rd_ch_i,
  input  logic                       ext_map_i,
  input  logic [NUM_CH-1:0]          compat_dis_i,
  input  logic [NUM_CH-1:0][ST_W-1:0] st_i,
  output logic [RD_W-1:0]            rd_data_o,
  output logic [NUM_CH-1:0]          clr_o
);
  logic [ST_W-1:0]  own;
  logic [EVT_W-1:0] prt;
  logic             pair_ok;
  int               p_idx;

  always_comb begin
    own     = '0;
    prt     = '0;
    pair_ok = 1'b0;
    p_idx   = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ch_i == CH_W'(c)) begin
        own     = st_i[c];
        pair_ok = !ext_map_i && !compat_dis_i[c] && has_partner(c, LEG_PAIRS, PAIR_OFS);
        p_idx   = partner_of(c, LEG_PAIRS, PAIR_OFS);
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (pair_ok && (p_idx == c)) prt = st_i[c][EVT_W-1:0];
    end
  end

  always_comb begin
    clr_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      clr_o[c] = rd_en_i && ((rd_ch_i == CH_W'(c)) || (pair_ok && (p_idx == c)));
    end
  end

  assign rd_data_o = rd_en_i ? (RD_W'(own) | (RD_W'(prt) << EVT_W)) : '0;
endmodule

// File: rtl/dma_irq_line_map.sv
module dma_irq_line_map
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int LEG_PAIRS = 3,
  parameter int PAIR_OFS  = 6,
  parameter int LEG_LINES = 6
) (
  input  logic                       ext_map_i,
  input  logic [NUM_CH-1:0][ST_W-1:0] st_i,
  output logic [NUM_CH-1:0]          irq_o
);
  logic [NUM_CH-1:0] any_st;
  logic [NUM_CH-1:0] leg_line;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_line
    localparam bit HP = has_partner(c, LEG_PAIRS, PAIR_OFS);
    localparam int PC = partner_of(c, LEG_PAIRS, PAIR_OFS);
    assign any_st[c] = |st_i[c];
    if (c < LEG_LINES && HP) begin : g_shared
      assign leg_line[c] = any_st[c] | (|st_i[PC]);
    end else if (c < LEG_LINES) begin : g_solo
      assign leg_line[c] = any_st[c];
    end else begin : g_off
      assign leg_line[c] = 1'b0;
    end
    assign irq_o[c] = ext_map_i ? any_st[c] : leg_line[c];
  end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int LEG_PAIRS = 3,
  parameter int PAIR_OFS  = 6,
  parameter int LEG_LINES = 6,
  parameter logic [EVT_W-1:0] IEN_RST = 6'h03,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ext_map_i,
  input  logic [NUM_CH-1:0]           compat_dis_i,
  input  logic [NUM_CH-1:0][EVT_W-1:0] evt_i,
  input  logic [NUM_CH-1:0]           sync_act_i,
  input  logic                        wr_en_i,
  input  logic                        wr_sel_i,
  input  logic [CH_W-1:0]             wr_ch_i,
  input  logic [EVT_W-1:0]            wr_data_i,
  input  logic                        rd_en_i,
  input  logic [CH_W-1:0]             rd_ch_i,
  output logic [RD_W-1:0]             rd_data_o,
  output logic [NUM_CH-1:0]           irq_o
);
  logic [NUM_CH-1:0][ST_W-1:0] st_q;
  logic [NUM_CH-1:0]           clr;
  logic [NUM_CH-1:0]           ien_we;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // wr_sel_i = 1 targets the read-only status register: dropped
    assign ien_we[c] = wr_en_i && !wr_sel_i && (wr_ch_i == CH_W'(c));

    dma_irq_ch_stat #(.IEN_RST(IEN_RST)) u_stat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[c]),
      .sync_act_i (sync_act_i[c]),
      .ien_we_i   (ien_we[c]),
      .ien_d_i    (wr_data_i),
      .clr_i      (clr[c]),
      .st_o       (st_q[c])
    );
  end

  dma_irq_rd_path #(
    .NUM_CH(NUM_CH), .LEG_PAIRS(LEG_PAIRS), .PAIR_OFS(PAIR_OFS)
  ) u_rd (
    .rd_en_i      (rd_en_i),
    .rd_ch_i      (rd_ch_i),
    .ext_map_i    (ext_map_i),
    .compat_dis_i (compat_dis_i),
    .st_i         (st_q),
    .rd_data_o    (rd_data_o),
    .clr_o        (clr)
  );

  dma_irq_line_map #(
    .NUM_CH(NUM_CH), .LEG_PAIRS(LEG_PAIRS), .PAIR_OFS(PAIR_OFS), .LEG_LINES(LEG_LINES)
  ) u_line (
    .ext_map_i (ext_map_i),
    .st_i      (st_q),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int LEG_LINES = 6,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        ext_map_i,
  input logic [NUM_CH-1:0][EVT_W-1:0] evt_i,
  input logic [NUM_CH-1:0]           sync_act_i,
  input logic                        rd_en_i,
  input logic [CH_W-1:0]             rd_ch_i,
  input logic [NUM_CH-1:0]           irq_o,
  input logic [NUM_CH-1:0][ST_W-1:0] st_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    p_drop_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[c][DROP_BIT] |=> st_q[c][DROP_BIT]);

    p_set_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((st_q[c][EVT_W-1:0] & ~$past(st_q[c][EVT_W-1:0]) & ~$past(evt_i[c])) == '0));

    p_sync_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (st_q[c][SYNC_BIT] == $past(sync_act_i[c])));

    p_rd_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && rd_ch_i == CH_W'(c) && evt_i[c] == '0) |=> (st_q[c][EVT_W-1:0] == '0));

    p_ext_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_map_i |-> (irq_o[c] == (st_q[c] != '0)));
  end

  if (LEG_LINES < NUM_CH) begin : g_hi
    p_legacy_hi_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ext_map_i |-> (irq_o[NUM_CH-1:LEG_LINES] == '0));
  end
endmodule

bind dma_irq_unit dma_irq_unit_chk #(.NUM_CH(NUM_CH), .LEG_LINES(LEG_LINES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_map_i  (ext_map_i),
  .evt_i      (evt_i),
  .sync_act_i (sync_act_i),
  .rd_en_i    (rd_en_i),
  .rd_ch_i    (rd_ch_i),
  .irq_o      (irq_o),
  .st_q       (st_q)
);

// File: tb/dma_irq_unit_tb_top.sv
`timescale 1ns/1ps
module dma_irq_unit_tb_top;
  localparam int NCH = 16;
  localparam logic [1:0] OP_WEN = 2'd0, OP_EVT = 2'd1, OP_RD = 2'd2, OP_WST = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  ch;
    logic [15:0] dat;
    logic [15:0] ex_rd;
    logic [15:0] ex_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{OP_EVT, 4'd0, 16'h0004, 16'h0000, 16'h0000, 4'd2},  // R2 half frame disabled
    '{OP_RD,  4'd0, 16'h0000, 16'h0000, 16'h0000, 4'd2},  // R2
    '{OP_EVT, 4'd0, 16'h0001, 16'h0000, 16'h0001, 4'd3},  // R3 timeout enabled at reset
    '{OP_RD,  4'd0, 16'h0000, 16'h0001, 16'h0000, 4'd4},  // R4
    '{OP_WEN, 4'd0, 16'h003F, 16'h0000, 16'h0000, 4'd3},  // R3
    '{OP_EVT, 4'd0, 16'h0028, 16'h0000, 16'h0001, 4'd1},  // R1 end frame + end block
    '{OP_WEN, 4'd6, 16'h0000, 16'h0000, 16'h0001, 4'd3},  // R3
    '{OP_EVT, 4'd6, 16'h0003, 16'h0000, 16'h0001, 4'd2},  // R2 drop only
    '{OP_RD,  4'd0, 16'h0000, 16'h00A8, 16'h0000, 4'd5},  // R5 partner in 11:6
    '{OP_RD,  4'd6, 16'h0000, 16'h0000, 16'h0000, 4'd5},  // R5 partner was cleared
    '{OP_EVT, 4'd7, 16'h0002, 16'h0000, 16'h0002, 4'd6},  // R6 ch7 on line 1
    '{OP_EVT, 4'd9, 16'h0001, 16'h0000, 16'h0002, 4'd6},  // R6 ch9 has no line
    '{OP_RD,  4'd9, 16'h0000, 16'h0001, 16'h0002, 4'd4},  // R4
    '{OP_RD,  4'd1, 16'h0000, 16'h0080, 16'h0000, 4'd5},  // R5
    '{OP_EVT, 4'd4, 16'h0001, 16'h0000, 16'h0010, 4'd6},  // R6
    '{OP_WST, 4'd4, 16'h0000, 16'h0000, 16'h0010, 4'd9},  // R9 status write ignored
    '{OP_RD,  4'd4, 16'h0000, 16'h0001, 16'h0000, 4'd9},  // R9
    '{OP_EVT, 4'd8, 16'h0031, 16'h0000, 16'h0004, 4'd6},  // R6 ch8 on line 2
    '{OP_RD,  4'd8, 16'h0000, 16'h0001, 16'h0000, 4'd5}   // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_map = 1'b0;
  logic [NCH-1:0] compat_dis = '0;
  logic [NCH-1:0][5:0] evt = '0;
  logic [NCH-1:0] sync_act = '0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0] wr_ch = '0;
  logic [5:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [3:0] rd_ch = '0;
  logic [15:0] rd_data;
  logic [NCH-1:0] irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] got_rd, got_irq;

  always #10 clk = ~clk;

  dma_irq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_map_i(ext_map), .compat_dis_i(compat_dis),
    .evt_i(evt), .sync_act_i(sync_act), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_ch_i(wr_ch), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_ch_i(rd_ch),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // finish one cycle: read data sampled mid-cycle, lines after the edge
  task automatic close_cycle();
    #2 got_rd = rd_data;
    @(posedge clk);
    #1;
    evt = '0; wr_en = 0; wr_sel = 0; rd_en = 0;
    got_irq = irq;
  endtask

  task automatic step(logic [1:0] op, logic [3:0] ch, logic [15:0] dat);
    @(negedge clk);
    case (op)
      OP_WEN: begin wr_en = 1; wr_sel = 0; wr_ch = ch; wr_data = dat[5:0]; end
      OP_WST: begin wr_en = 1; wr_sel = 1; wr_ch = ch; wr_data = dat[5:0]; end
      OP_EVT: evt[ch] = dat[5:0];
      default: begin rd_en = 1; rd_ch = ch; end
    endcase
    close_cycle();
  endtask

  task automatic idle();
    @(negedge clk);
    close_cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    idle();
    chk("R11 lines after reset", got_irq, 16'h0000);
    step(OP_RD, 4'd5, 16'h0);
    chk("R11 status after reset", got_rd, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].ch, VECS[i].dat);
      if (VECS[i].op == OP_RD)
        chk($sformatf("R%0d vec %0d rd", VECS[i].req, i), got_rd, VECS[i].ex_rd);
      chk($sformatf("R%0d vec %0d irq", VECS[i].req, i), got_irq, VECS[i].ex_irq);
    end

    // R10 event and clearing read in the same cycle
    step(OP_EVT, 4'd3, 16'h0001);
    @(negedge clk);
    rd_en = 1; rd_ch = 4'd3; evt[3] = 6'h02;
    close_cycle();
    chk("R10 collision rd", got_rd, 16'h0001);
    chk("R10 collision line", got_irq, 16'h0008);
    step(OP_RD, 4'd3, 16'h0);
    chk("R10 event kept", got_rd, 16'h0002);

    // R8 sync bit
    @(negedge clk); sync_act[2] = 1'b1; close_cycle();
    chk("R8 sync line", got_irq, 16'h0004);
    step(OP_RD, 4'd2, 16'h0);
    chk("R8 sync read", got_rd, 16'h0040);
    chk("R8 sync survives read", got_irq, 16'h0004);
    @(negedge clk); sync_act[2] = 1'b0; close_cycle();
    chk("R8 sync drop line", got_irq, 16'h0000);
    step(OP_RD, 4'd2, 16'h0);
    chk("R8 sync cleared", got_rd, 16'h0000);

    // R5 compatibility-disable suppresses pairing
    compat_dis[0] = 1'b1;
    step(OP_EVT, 4'd6, 16'h0002);
    step(OP_RD, 4'd0, 16'h0);
    chk("R5 compat no partner", got_rd, 16'h0000);
    chk("R5 compat partner kept", got_irq, 16'h0001);
    step(OP_RD, 4'd6, 16'h0);
    chk("R5 compat partner own read", got_rd, 16'h0002);
    chk("R5 compat line clear", got_irq, 16'h0000);
    compat_dis[0] = 1'b0;

    // R7 extended mapping
    ext_map = 1'b1;
    step(OP_EVT, 4'd12, 16'h0001);
    chk("R7 ext line 12", got_irq, 16'h1000);
    step(OP_EVT, 4'd6, 16'h0002);
    chk("R7 ext line 6", got_irq, 16'h1040);
    step(OP_EVT, 4'd0, 16'h0001);
    chk("R7 ext line 0", got_irq, 16'h1041);
    step(OP_RD, 4'd0, 16'h0);
    chk("R7 ext read alone", got_rd, 16'h0001);
    chk("R7 ext partner untouched", got_irq, 16'h1040);
    step(OP_RD, 4'd6, 16'h0);
    chk("R7 ext read ch6", got_rd, 16'h0002);
    step(OP_RD, 4'd12, 16'h0);
    chk("R7 ext read ch12", got_rd, 16'h0001);
    chk("R7 ext all low", got_irq, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule